// File: doc/BRIEF.md
# Set-Associative Victim Way Selector

This block chooses one way of a single cache set for an incoming block address. Each cycle it receives every way's stored tag, its valid bit and its lock bit, along with the lookup tag. From these it returns three results in the same cycle: a hit flag, the way to use, and a flag that says no way can be used. A hit always wins. Before the full scan, the tag of the most recently used way is compared first as a fast path. On a miss, an empty way comes before any filled way. When every way is filled, the block picks a victim by the configured policy. That policy is either plain least-recently-used or next-to-least-recently-used.

The set's recency order is held inside the block as one rank per way, from 0 for the most recent way to ASSOC-1 for the least recent. The ranks are brought out on a port. When the caller asserts `commit` together with a way index, the ranks are updated on that clock edge. The policy input is a static configuration setting. A cache that wants the second policy can select it, while other cache-like structures built from the same block stay on plain LRU. Locked lines are skipped. There are defined fallbacks for the cases where only one line is unlocked or no line is unlocked.

Top module: `way_select_top`

## Requirements
- R1: If any valid way's tag equals `lookup_tag`, `hit` is 1, `none_found` is 0 and `sel_way` is a matching way. This holds under either policy and whatever the lock bits are.
- R2: The rank-0 (most recent) way is compared first. If it is valid and matches, it is returned even when another valid way also matches. Otherwise the matching way with the highest rank is returned.
- R3: On a miss with at least one invalid way, `sel_way` is the invalid way with the lowest rank. A way may never be presented as locked while invalid, and the checker flags any such input.
- R4: With `policy`=0 (LRU), on a miss with all ways valid and at least one unlocked, `sel_way` is the unlocked way with the highest rank.
- R5: With `policy`=1 (next-to-LRU), on a miss with all ways valid and at least two unlocked, `sel_way` is the unlocked way with the second-highest rank among the unlocked ways.
- R6: With `policy`=1, on a miss with all ways valid and exactly one unlocked, `sel_way` is that way.
- R7: With `policy`=0, on a miss with all ways valid and locked, `none_found` is 1 and `sel_way` is 0 when `ignore_locked`=0. When `ignore_locked`=1, `none_found` is 0 and `sel_way` is the way of rank ASSOC-1.
- R8: With `policy`=1, on a miss with all ways valid and locked, `sel_way` is the way of rank ASSOC-2 and `none_found` is 0, whatever `ignore_locked` is.
- R9: After reset, way i has rank i. At a rising edge with `commit`=1, the committed way becomes rank 0, every way ranked below its old rank gains one, and the others keep their rank. With `commit`=0 the ranks do not change.
- R10: `rank_out` carries the rank of way i in bits [i*WAY_W +: WAY_W], and the ranks always form a permutation of 0..ASSOC-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_tag | input | TAG_W | Tag of the incoming block address |
| way_tag | input | ASSOC*TAG_W | Stored tag of way i in bits [i*TAG_W +: TAG_W] |
| way_valid | input | ASSOC | Valid bit per way |
| way_lock | input | ASSOC | Lock bit per way |
| policy | input | 1 | 0 = LRU, 1 = next-to-LRU (static) |
| ignore_locked | input | 1 | Allow an LRU victim when all ways are locked |
| commit | input | 1 | Apply a recency update at this edge |
| commit_way | input | WAY_W | Way made most recent by the commit |
| hit | output | 1 | A valid way holds the lookup tag |
| sel_way | output | WAY_W | Selected way (hit or victim) |
| none_found | output | 1 | No way can be chosen |
| rank_out | output | ASSOC*WAY_W | Current recency rank of each way |

## Verification
Lookups are tried against a set whose recency order has first been shuffled by commits. Every combination of lock mask, policy and ignore-locked flag is swept while all ways are valid. This sweep separates the highest-unlocked-rank choice from the second-highest, and it exercises the single-unlocked and all-locked fallbacks. Directed cases also cover several other inputs. Duplicate tags in the most recent way and in a stale way tell the fast path apart from the plain scan. Several invalid ways at different ranks show which empty way is preferred. A hit on a locked, least recent way under next-to-LRU shows that hits override the policy. Commit and no-commit cycles are checked against an independent ordered-list model of recency.

// File: rtl/way_select_pkg.sv
`timescale 1ns/1ps
package way_select_pkg;
    typedef enum logic {
        POL_LRU   = 1'b0,
        POL_NXLRU = 1'b1
    } repl_pol_e;
endpackage

// File: rtl/way_rank_tracker.sv
`timescale 1ns/1ps
// Holds the recency rank of every way (0 = most recent).
module way_rank_tracker #(
    parameter int ASSOC = 4,
    parameter int WAY_W = $clog2(ASSOC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  logic [WAY_W-1:0]            commit_way,
    output logic [ASSOC-1:0][WAY_W-1:0] rank_q
);
    typedef struct packed {
        logic [ASSOC-1:0][WAY_W-1:0] rank;
    } rank_st_t;

    rank_st_t st_d, st_q;
    logic [WAY_W-1:0] old_rank;

    always_comb begin
        st_d     = st_q;
        old_rank = '0;
        for (int i = 0; i < ASSOC; i++) begin
            if (WAY_W'(i) == commit_way) old_rank = st_q.rank[i];
        end
        if (commit) begin
            for (int i = 0; i < ASSOC; i++) begin
                if (WAY_W'(i) == commit_way) begin
                    st_d.rank[i] = '0;
                end else if (st_q.rank[i] < old_rank) begin
                    st_d.rank[i] = st_q.rank[i] + WAY_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ASSOC; i++) st_q.rank[i] <= WAY_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    assign rank_q = st_q.rank;
endmodule

// File: rtl/way_hit_detect.sv
`timescale 1ns/1ps
// Tag comparison: most-recent way first, then the rest of the set.
module way_hit_detect #(
    parameter int ASSOC = 4,
    parameter int TAG_W = 20,
    parameter int WAY_W = $clog2(ASSOC)
) (
    input  logic [TAG_W-1:0]            lookup_tag,
    input  logic [ASSOC-1:0][TAG_W-1:0] tags,
    input  logic [ASSOC-1:0]            valid,
    input  logic [ASSOC-1:0][WAY_W-1:0] rank,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [ASSOC-1:0] match;
    logic [ASSOC-1:0] is_mru;
    logic             mru_hit;
    logic [WAY_W-1:0] mru_way;
    logic [WAY_W-1:0] scan_way;
    logic [WAY_W-1:0] scan_rank;
    logic             scan_any;

    always_comb begin
        for (int i = 0; i < ASSOC; i++) begin
            match[i]  = valid[i] && (tags[i] == lookup_tag);
            is_mru[i] = (rank[i] == '0);
        end
    end

    // fast path on the way that holds rank 0
    always_comb begin
        mru_way = '0;
        for (int i = 0; i < ASSOC; i++) begin
            if (is_mru[i]) mru_way = WAY_W'(i);
        end
        mru_hit = |(match & is_mru);
    end

    // full scan: oldest matching way
    always_comb begin
        scan_any  = 1'b0;
        scan_way  = '0;
        scan_rank = '0;
        for (int i = 0; i < ASSOC; i++) begin
            if (match[i] && (!scan_any || rank[i] > scan_rank)) begin
                scan_any  = 1'b1;
                scan_way  = WAY_W'(i);
                scan_rank = rank[i];
            end
        end
    end

    assign hit     = mru_hit || scan_any;
    assign hit_way = mru_hit ? mru_way : scan_way;
endmodule

// File: rtl/way_victim_pick.sv
`timescale 1ns/1ps
// Victim choice on a miss: invalid ways first, then the policy.
module way_victim_pick
    import way_select_pkg::*;
#(
    parameter int ASSOC = 4,
    parameter int WAY_W = $clog2(ASSOC)
) (
    input  logic [ASSOC-1:0]            valid,
    input  logic [ASSOC-1:0]            lock,
    input  logic [ASSOC-1:0][WAY_W-1:0] rank,
    input  repl_pol_e                   policy,
    input  logic                        ignore_locked,
    output logic [WAY_W-1:0]            vict_way,
    output logic                        vict_none
);
    localparam int CNT_W = $clog2(ASSOC + 1);

    logic [ASSOC-1:0]            inv;
    logic [ASSOC-1:0]            free;
    logic [ASSOC-1:0][CNT_W-1:0] older_free;
    logic [ASSOC-1:0]            newer_inv;
    logic [CNT_W-1:0]            free_cnt;
    logic [ASSOC-1:0]            cand;

    always_comb begin
        inv  = ~valid;
        free = valid & ~lock;
        for (int i = 0; i < ASSOC; i++) begin
            older_free[i] = '0;
            newer_inv[i]  = 1'b0;
            for (int j = 0; j < ASSOC; j++) begin
                if (free[j] && rank[j] > rank[i]) older_free[i] = older_free[i] + CNT_W'(1);
                if (inv[j] && rank[j] < rank[i])  newer_inv[i]  = 1'b1;
            end
        end
        free_cnt = CNT_W'($countones(free));
    end

    always_comb begin
        cand      = '0;
        vict_none = 1'b0;
        if (|inv) begin
            for (int i = 0; i < ASSOC; i++) cand[i] = inv[i] && !newer_inv[i];
        end else if (policy == POL_LRU) begin
            if (|free) begin
                for (int i = 0; i < ASSOC; i++) cand[i] = free[i] && (older_free[i] == '0);
            end else if (ignore_locked) begin
                for (int i = 0; i < ASSOC; i++) cand[i] = (rank[i] == WAY_W'(ASSOC - 1));
            end else begin
                vict_none = 1'b1;
            end
        end else begin
            if (free_cnt >= CNT_W'(2)) begin
                for (int i = 0; i < ASSOC; i++) cand[i] = free[i] && (older_free[i] == CNT_W'(1));
            end else if (free_cnt == CNT_W'(1)) begin
                cand = free;
            end else begin
                for (int i = 0; i < ASSOC; i++) cand[i] = (rank[i] == WAY_W'(ASSOC - 2));
            end
        end
    end

    always_comb begin
        vict_way = '0;
        for (int i = ASSOC - 1; i >= 0; i--) begin
            if (cand[i]) vict_way = WAY_W'(i);
        end
    end
endmodule

// File: rtl/way_select_top.sv
`timescale 1ns/1ps
module way_select_top
    import way_select_pkg::*;
#(
    parameter int ASSOC = 4,
    parameter int TAG_W = 20,
    parameter int WAY_W = $clog2(ASSOC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TAG_W-1:0]         lookup_tag,
    input  logic [ASSOC*TAG_W-1:0]   way_tag,
    input  logic [ASSOC-1:0]         way_valid,
    input  logic [ASSOC-1:0]         way_lock,
    input  logic                     policy,
    input  logic                     ignore_locked,
    input  logic                     commit,
    input  logic [WAY_W-1:0]         commit_way,
    output logic                     hit,
    output logic [WAY_W-1:0]         sel_way,
    output logic                     none_found,
    output logic [ASSOC*WAY_W-1:0]   rank_out
);
    logic [ASSOC-1:0][WAY_W-1:0] rank_q;
    logic [ASSOC-1:0][TAG_W-1:0] tags;
    logic                        hd_hit;
    logic [WAY_W-1:0]            hd_way;
    logic [WAY_W-1:0]            vp_way;
    logic                        vp_none;
    repl_pol_e                   pol;

    assign tags = way_tag;
    assign pol  = repl_pol_e'(policy);

    way_rank_tracker #(.ASSOC(ASSOC), .WAY_W(WAY_W)) u_rank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_way (commit_way),
        .rank_q     (rank_q)
    );

    way_hit_detect #(.ASSOC(ASSOC), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_hit (
        .lookup_tag (lookup_tag),
        .tags       (tags),
        .valid      (way_valid),
        .rank       (rank_q),
        .hit        (hd_hit),
        .hit_way    (hd_way)
    );

    way_victim_pick #(.ASSOC(ASSOC), .WAY_W(WAY_W)) u_vict (
        .valid         (way_valid),
        .lock          (way_lock),
        .rank          (rank_q),
        .policy        (pol),
        .ignore_locked (ignore_locked),
        .vict_way      (vp_way),
        .vict_none     (vp_none)
    );

    assign hit        = hd_hit;
    assign sel_way    = hd_hit ? hd_way : vp_way;
    assign none_found = !hd_hit && vp_none;
    assign rank_out   = rank_q;
endmodule

// File: rtl/way_select_chk.sv
`timescale 1ns/1ps
module way_select_chk #(
    parameter int ASSOC = 4,
    parameter int TAG_W = 20,
    parameter int WAY_W = $clog2(ASSOC)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [TAG_W-1:0]       lookup_tag,
    input logic [ASSOC*TAG_W-1:0] way_tag,
    input logic [ASSOC-1:0]       way_valid,
    input logic [ASSOC-1:0]       way_lock,
    input logic                   policy,
    input logic                   ignore_locked,
    input logic                   commit,
    input logic [WAY_W-1:0]       commit_way,
    input logic                   hit,
    input logic [WAY_W-1:0]       sel_way,
    input logic                   none_found,
    input logic [ASSOC*WAY_W-1:0] rank_out
);
    logic [WAY_W-1:0] last_way;
    logic [WAY_W-1:0] mru_idx;
    logic             mru_match;
    logic             sel_match;

    always_ff @(posedge clk) begin
        if (!rst_n)      last_way <= '0;
        else if (commit) last_way <= commit_way;
    end

    always_comb begin
        mru_idx = '0;
        for (int i = 0; i < ASSOC; i++) begin
            if (rank_out[i*WAY_W +: WAY_W] == '0) mru_idx = WAY_W'(i);
        end
        mru_match = way_valid[mru_idx] && (way_tag[mru_idx*TAG_W +: TAG_W] == lookup_tag);
        sel_match = way_valid[sel_way] && (way_tag[sel_way*TAG_W +: TAG_W] == lookup_tag);
    end

    a_r1_hit_is_match: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> sel_match && !none_found);

    a_r2_mru_first: assert property (@(posedge clk) disable iff (!rst_n)
        mru_match |-> hit && sel_way == mru_idx);

    a_r3_no_invalid_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (way_lock & ~way_valid) == '0);

    a_r3_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && way_valid != '1) |-> !way_valid[sel_way]);

    a_r7_none_only_lru: assert property (@(posedge clk) disable iff (!rst_n)
        none_found |-> !policy && !ignore_locked && way_lock == '1);

    a_r9_commit_to_mru: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> rank_out[last_way*WAY_W +: WAY_W] == '0);

    a_r9_hold_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(rank_out));

    for (genvar v = 0; v < ASSOC; v++) begin : g_perm
        logic [ASSOC-1:0] holds;
        always_comb begin
            for (int i = 0; i < ASSOC; i++) holds[i] = (rank_out[i*WAY_W +: WAY_W] == WAY_W'(v));
        end
        a_r10_rank_unique: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(holds) == 1);
    end
endmodule

bind way_select_top way_select_chk #(.ASSOC(ASSOC), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lookup_tag    (lookup_tag),
    .way_tag       (way_tag),
    .way_valid     (way_valid),
    .way_lock      (way_lock),
    .policy        (policy),
    .ignore_locked (ignore_locked),
    .commit        (commit),
    .commit_way    (commit_way),
    .hit           (hit),
    .sel_way       (sel_way),
    .none_found    (none_found),
    .rank_out      (rank_out)
);

// File: tb/way_select_top_test.sv
`timescale 1ns/1ps
module way_select_top_test;
    localparam int ASSOC = 4;
    localparam int TAG_W = 8;
    localparam int WAY_W = 2;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [TAG_W-1:0]       lookup_tag = '0;
    logic [ASSOC*TAG_W-1:0] way_tag = '0;
    logic [ASSOC-1:0]       way_valid = '0;
    logic [ASSOC-1:0]       way_lock = '0;
    logic                   policy = 1'b0;
    logic                   ignore_locked = 1'b0;
    logic                   commit = 1'b0;
    logic [WAY_W-1:0]       commit_way = '0;
    logic                   hit;
    logic [WAY_W-1:0]       sel_way;
    logic                   none_found;
    logic [ASSOC*WAY_W-1:0] rank_out;

    int checks = 0;
    int fails  = 0;
    int order[ASSOC];   // bench recency list, most recent first

    always #2.5 clk = ~clk;

    way_select_top #(.ASSOC(ASSOC), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n), .lookup_tag(lookup_tag), .way_tag(way_tag),
        .way_valid(way_valid), .way_lock(way_lock), .policy(policy),
        .ignore_locked(ignore_locked), .commit(commit), .commit_way(commit_way),
        .hit(hit), .sel_way(sel_way), .none_found(none_found), .rank_out(rank_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_tags(input int t0, input int t1, input int t2, input int t3);
        way_tag = {TAG_W'(t3), TAG_W'(t2), TAG_W'(t1), TAG_W'(t0)};
    endtask

    task automatic apply(input int tag, input logic [3:0] v, input logic [3:0] l,
                         input logic pol, input logic ign);
        @(negedge clk);
        lookup_tag = TAG_W'(tag); way_valid = v; way_lock = l;
        policy = pol; ignore_locked = ign;
        #1;
    endtask

    task automatic do_commit(input int w);
        int pos = 0;
        @(negedge clk);
        commit = 1'b1; commit_way = WAY_W'(w);
        @(negedge clk);
        commit = 1'b0;
        for (int i = 0; i < ASSOC; i++) if (order[i] == w) pos = i;
        for (int i = pos; i > 0; i--) order[i] = order[i-1];
        order[0] = w;
    endtask

    task automatic check_ranks(input string req);
        for (int i = 0; i < ASSOC; i++) begin
            int r = 0;
            for (int k = 0; k < ASSOC; k++) if (order[k] == i) r = k;
            check(req, int'(rank_out[i*WAY_W +: WAY_W]), r);
        end
    endtask

    // expected victim from the recency list; -1 means none found
    function automatic int exp_victim(input logic [3:0] l, input logic pol, input logic ign);
        int seen = 0;
        int first = -1;
        for (int k = ASSOC - 1; k >= 0; k--) begin
            if (!l[order[k]]) begin
                seen++;
                if (seen == 1) first = order[k];
                if (!pol && seen == 1) return order[k];
                if (pol && seen == 2) return order[k];
            end
        end
        if (pol) return (seen == 1) ? first : order[ASSOC-2];
        return ign ? order[ASSOC-1] : -1;
    endfunction

    task automatic t_reset;
        for (int i = 0; i < ASSOC; i++) order[i] = i;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_ranks("R9 reset ranks");
    endtask

    task automatic t_hit;
        set_tags(8'h11, 8'h22, 8'h33, 8'h44);
        apply(8'h33, 4'hF, 4'h0, 1'b0, 1'b0);
        check("R1 hit flag", hit, 1);
        check("R1 hit way", sel_way, 2);
        check("R1 hit none_found", none_found, 0);
        // hit on locked LRU way under next-to-LRU still wins
        apply(8'h44, 4'hF, 4'hF, 1'b1, 1'b0);
        check("R1 hit NX locked", hit, 1);
        check("R1 hit NX way", sel_way, 3);
    endtask

    task automatic t_fast_path;
        // way0 is rank 0, way3 rank 3, both hold tag 55
        set_tags(8'h55, 8'h22, 8'h33, 8'h55);
        apply(8'h55, 4'hF, 4'h0, 1'b0, 1'b0);
        check("R2 MRU duplicate", sel_way, 0);
        set_tags(8'h55, 8'h22, 8'h55, 8'h55);
        apply(8'h55, 4'hE, 4'h0, 1'b0, 1'b0);   // way0 invalid
        check("R2 scan oldest match", sel_way, 3);
        check("R2 scan hit", hit, 1);
    endtask

    task automatic t_invalid;
        set_tags(8'h01, 8'h02, 8'h03, 8'h04);
        apply(8'h99, 4'b1010, 4'b1000, 1'b1, 1'b0);
        check("R3 invalid most recent", sel_way, 0);
        check("R3 miss", hit, 0);
        do_commit(2);
        check_ranks("R9 commit way2");
        apply(8'h99, 4'b1010, 4'b1000, 1'b0, 1'b0);
        check("R3 invalid after commit", sel_way, 2);
    endtask

    task automatic t_directed_policy;
        // order now 2,0,1,3
        set_tags(8'h01, 8'h02, 8'h03, 8'h04);
        apply(8'h99, 4'hF, 4'b1000, 1'b0, 1'b0);
        check("R4 LRU skips locked", sel_way, 1);
        apply(8'h99, 4'hF, 4'b0000, 1'b1, 1'b0);
        check("R5 NX second oldest", sel_way, 1);
        apply(8'h99, 4'hF, 4'b1011, 1'b1, 1'b0);
        check("R6 NX single unlocked", sel_way, 2);
        apply(8'h99, 4'hF, 4'hF, 1'b0, 1'b0);
        check("R7 none_found", none_found, 1);
        check("R7 sel zero", sel_way, 0);
        apply(8'h99, 4'hF, 4'hF, 1'b0, 1'b1);
        check("R7 ignore locked none", none_found, 0);
        check("R7 ignore locked way", sel_way, 3);
        apply(8'h99, 4'hF, 4'hF, 1'b1, 1'b0);
        check("R8 NX all locked", sel_way, 1);
        check("R8 NX all locked none", none_found, 0);
    endtask

    task automatic t_hold;
        @(negedge clk); commit_way = 2'd3;
        repeat (3) @(negedge clk);
        check_ranks("R9 no commit hold");
        check("R10 field way3", int'(rank_out[7:6]), 3);
    endtask

    task automatic t_sweep;
        do_commit(3); do_commit(1); do_commit(0);
        check_ranks("R9 commit sequence");
        do_commit(0);
        check_ranks("R9 commit of MRU");
        set_tags(8'h01, 8'h02, 8'h03, 8'h04);
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int g = 0; g < 2; g++) begin
                    int e = exp_victim(4'(m), 1'(p), 1'(g));
                    apply(8'h99, 4'hF, 4'(m), 1'(p), 1'(g));
                    if (e < 0) begin
                        check("R7 sweep none", none_found, 1);
                    end else begin
                        check(p ? "R5 R6 R8 sweep" : "R4 R7 sweep", sel_way, e);
                        check("R4 sweep none", none_found, 0);
                    end
                end
            end
        end
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_hit();
        t_fast_path();
        t_invalid();
        t_directed_policy();
        t_hold();
        t_sweep();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule